// File: doc/BRIEF.md
# Time-Slotted Frame Memory Port Arbiter

This block lets two agents share one byte-wide asynchronous SRAM: a raster scan-out engine that reads one byte of 1-bit-per-pixel image data per character cell, and a CPU write snooper that holds a cached word address, two data bytes and two pending flags. There is no request and grant handshake. Every eight pixel clocks form one character cell, and the low three bits of the horizontal pixel counter pick the slot within it. Each kind of access owns a fixed slot: the low data byte is written in slot 1, the high data byte in slot 2, and the video byte is read in slot 7. Neither side ever stalls, and the worst-case wait for a cached CPU byte is one cell.

The SRAM strobes are decoded straight from the slot counter and the request inputs. When a write slot is used, the block pulses an acknowledge output so that the snooper can clear its pending flag. The byte read in slot 7 is captured on the pixel clock edge that ends the slot and is held for the following cell, which is the cell it was fetched for. The image is 512 pixels wide, so each line takes 64 bytes. The fetch address is the line number times 64 plus the byte column of the next cell.

Top module: `vram_slot_arbiter`

## Requirements
- R1: When `hcount[2:0]` is 1 and `wr_lo_pend` is high, the block drives `sram_we_n` low and `sram_dout_en` high, puts `wr_lo_byte` on `sram_dout`, and drives `sram_addr` = {`snoop_word_addr`, 1'b0}.
- R2: When `hcount[2:0]` is 2 and `wr_hi_pend` is high, the block drives `sram_we_n` low and `sram_dout_en` high, puts `wr_hi_byte` on `sram_dout`, and drives `sram_addr` = {`snoop_word_addr`, 1'b1}.
- R3: In every other cycle, including slot 1 or slot 2 with the matching pending flag low, `sram_we_n` is high and `sram_dout_en` is low, so the data pads are released.
- R4: `sram_oe_n` is low exactly when `hcount[2:0]` is 7 and `disp_active` is high, and is high in every other cycle.
- R5: In every cycle without a granted write, `sram_addr` = `vcount` * 64 + ((`hcount` / 8 + 1) mod 64), truncated to 15 bits. This is the byte of the next cell.
- R6: On the rising edge that ends a cycle with `sram_oe_n` low, `pix_byte` takes the value of `sram_din`. In every other cycle `pix_byte` holds its value.
- R7: `wr_lo_ack` is high in exactly the cycles in which the low byte is written (R1), and `wr_hi_ack` in exactly those in which the high byte is written (R2).
- R8: While `rst_n` is low, `sram_we_n` and `sram_oe_n` are high and `sram_dout_en`, `wr_lo_ack` and `wr_hi_ack` are low, whatever the other inputs are. A clock edge with `rst_n` low clears `pix_byte` to 0.
- R9: `sram_we_n` and `sram_oe_n` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset; also gates the strobes combinationally |
| hcount | input | 10 | Horizontal pixel counter; bits 2:0 are the slot |
| vcount | input | 10 | Display line number |
| disp_active | input | 1 | Video fetch window active |
| snoop_word_addr | input | 14 | Cached CPU word offset from the frame base |
| wr_lo_byte | input | 8 | Cached low data byte |
| wr_hi_byte | input | 8 | Cached high data byte |
| wr_lo_pend | input | 1 | Low byte waiting to be written |
| wr_hi_pend | input | 1 | High byte waiting to be written |
| sram_addr | output | 15 | SRAM byte address |
| sram_dout | output | 8 | Write data toward the pads |
| sram_dout_en | output | 1 | Pad driver enable; low means the bus is high impedance |
| sram_din | input | 8 | Read data from the pads |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| wr_lo_ack | output | 1 | Low byte written this cycle |
| wr_hi_ack | output | 1 | High byte written this cycle |
| pix_byte | output | 8 | Latched video byte for the current cell |

## Verification
The bench sweeps every slot of whole raster lines, including the first and last image lines and lines past the image, with the pending flags and the display flag varying from cycle to cycle. The cases it targets are these. A write slot whose flag is low must leave the pads released; a design that writes anyway corrupts image memory. The last cell of a line must wrap its fetch column to 0; a design that does not wrap reads from the next line. The low and high bytes must not swap their address bit 0; a swapped design mirrors the bytes of every word. A read strobe that fires outside the display window, or a captured byte that is not held, would show up as wrong pixels on the border. Reset is applied while a write slot is live, to show that the strobes are gated during reset.

// File: rtl/vram_arb_pkg.sv
// Package: slot assignments and access-owner type shared by the arbiter.
// Assumes an eight-slot cell (three slot bits); the slot numbers are fixed
// by the schedule and are not meant to be changed per instance.
package vram_arb_pkg;
    localparam int SLOT_BITS = 3;
    localparam int SLOT_LO   = 1;   // low data byte write
    localparam int SLOT_HI   = 2;   // high data byte write
    localparam int SLOT_RD   = 7;   // video byte read

    typedef enum logic [1:0] {
        OWNER_NONE = 2'd0,
        OWNER_LO   = 2'd1,
        OWNER_HI   = 2'd2,
        OWNER_RD   = 2'd3
    } owner_e;

    // Slot owned by write lane 0 (low byte) or lane 1 (high byte).
    function automatic int lane_slot(input int lane);
        return (lane == 0) ? SLOT_LO : SLOT_HI;
    endfunction
endpackage

// File: rtl/vram_slot_decode.sv
// Slot decoder: turns the slot number and the request inputs into grants
// and one owner for the cycle. Assumes the slot field cycles through all
// values. Every grant is forced off while reset is low.
module vram_slot_decode
    import vram_arb_pkg::*;
#(
    parameter int SLOT_W = SLOT_BITS
) (
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot,
    input  logic [1:0]        pend,
    input  logic              disp_active,
    output logic [1:0]        wr_grant,
    output logic              rd_grant,
    output owner_e            owner
);
    // One write lane per data byte, each bound to its own slot.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign wr_grant[g] = rst_n && pend[g] && (slot == SLOT_W'(lane_slot(g)));
    end

    // Video read is granted only inside the fetch window.
    assign rd_grant = rst_n && disp_active && (slot == SLOT_W'(SLOT_RD));

    // Pick the single owner; the slots are disjoint, so the order only documents intent.
    always_comb begin
        if (wr_grant[0])      owner = OWNER_LO;
        else if (wr_grant[1]) owner = OWNER_HI;
        else if (rd_grant)    owner = OWNER_RD;
        else                  owner = OWNER_NONE;
    end
endmodule

// File: rtl/vram_fetch_addr.sv
// Fetch address generator: the byte address of the next character cell on
// the current line, i.e. line * 2**COL_W + (cell + 1) mod 2**COL_W.
// Assumes one bit per pixel and 2**COL_W bytes per line.
module vram_fetch_addr #(
    parameter int CNT_W  = 10,
    parameter int SLOT_W = 3,
    parameter int COL_W  = 6,
    parameter int ADDR_W = 15
) (
    input  logic [CNT_W-1:0]  hcount,
    input  logic [CNT_W-1:0]  vcount,
    output logic [ADDR_W-1:0] fetch_addr
);
    logic [COL_W-1:0] next_col;

    // Column of the following cell; it wraps within the line.
    assign next_col = COL_W'((hcount >> SLOT_W) + 1'b1);

    // Line number above the column field, truncated to the SRAM width.
    assign fetch_addr = ADDR_W'({vcount, next_col});
endmodule

// File: rtl/vram_read_latch.sv
// Read latch: captures the SRAM read byte on the edge that ends the read
// slot and holds it for the next cell. Synchronous active-low reset.
module vram_read_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);
    // Hold register for the fetched byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (capture) q <= din;
    end
endmodule

// File: rtl/vram_slot_arbiter.sv
// Top: fixed time-slot sharing of one byte-wide SRAM between video fetch
// and cached CPU writes. Strobes are combinational from the slot and the
// requests, so hcount is expected to come straight from a register.
// Write data leaves through sram_dout, and sram_dout_en drives the pad
// tristate; read data returns on sram_din.
module vram_slot_arbiter
    import vram_arb_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int COL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  hcount,
    input  logic [CNT_W-1:0]  vcount,
    input  logic              disp_active,
    input  logic [ADDR_W-2:0] snoop_word_addr,
    input  logic [DATA_W-1:0] wr_lo_byte,
    input  logic [DATA_W-1:0] wr_hi_byte,
    input  logic              wr_lo_pend,
    input  logic              wr_hi_pend,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dout,
    output logic              sram_dout_en,
    input  logic [DATA_W-1:0] sram_din,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic              wr_lo_ack,
    output logic              wr_hi_ack,
    output logic [DATA_W-1:0] pix_byte
);
    localparam int SLOT_W = SLOT_BITS;

    logic [1:0]        wr_grant;
    logic              rd_grant;
    owner_e            owner;
    logic [ADDR_W-1:0] fetch_addr;

    vram_slot_decode #(.SLOT_W(SLOT_W)) i_decode (
        .rst_n       (rst_n),
        .slot        (hcount[SLOT_W-1:0]),
        .pend        ({wr_hi_pend, wr_lo_pend}),
        .disp_active (disp_active),
        .wr_grant    (wr_grant),
        .rd_grant    (rd_grant),
        .owner       (owner)
    );

    vram_fetch_addr #(
        .CNT_W  (CNT_W),
        .SLOT_W (SLOT_W),
        .COL_W  (COL_W),
        .ADDR_W (ADDR_W)
    ) i_fetch (
        .hcount     (hcount),
        .vcount     (vcount),
        .fetch_addr (fetch_addr)
    );

    vram_read_latch #(.DATA_W(DATA_W)) i_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (rd_grant),
        .din     (sram_din),
        .q       (pix_byte)
    );

    // Drive the SRAM pins and acknowledges from the owner of this slot.
    always_comb begin
        sram_addr    = fetch_addr;
        sram_dout    = '0;
        sram_dout_en = 1'b0;
        sram_we_n    = 1'b1;
        sram_oe_n    = 1'b1;
        wr_lo_ack    = 1'b0;
        wr_hi_ack    = 1'b0;
        unique case (owner)
            OWNER_LO: begin
                sram_addr    = {snoop_word_addr, 1'b0};
                sram_dout    = wr_lo_byte;
                sram_dout_en = 1'b1;
                sram_we_n    = 1'b0;
                wr_lo_ack    = 1'b1;
            end
            OWNER_HI: begin
                sram_addr    = {snoop_word_addr, 1'b1};
                sram_dout    = wr_hi_byte;
                sram_dout_en = 1'b1;
                sram_we_n    = 1'b0;
                wr_hi_ack    = 1'b1;
            end
            OWNER_RD: sram_oe_n = 1'b0;
            default: ;
        endcase
    end
endmodule

// File: rtl/vram_slot_arbiter_chk.sv
// Checker for vram_slot_arbiter: the relations between the slot, the
// requests and the SRAM pins over time. Bound to every instance of the top.
module vram_slot_arbiter_chk #(
    parameter int CNT_W  = 10,
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  hcount,
    input logic              disp_active,
    input logic              wr_lo_pend,
    input logic              wr_hi_pend,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_din,
    input logic              sram_dout_en,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic              wr_lo_ack,
    input logic              wr_hi_ack,
    input logic [DATA_W-1:0] pix_byte
);
    AST_WE_IN_WRITE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> ((hcount[2:0] == 3'd1 && wr_lo_pend) || (hcount[2:0] == 3'd2 && wr_hi_pend))); // R3
    AST_LO_SLOT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (hcount[2:0] == 3'd1 && wr_lo_pend) |-> (!sram_we_n && sram_dout_en && !sram_addr[0])); // R1
    AST_HI_SLOT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (hcount[2:0] == 3'd2 && wr_hi_pend) |-> (!sram_we_n && sram_dout_en && sram_addr[0])); // R2
    AST_PADS_FOLLOW_WE: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dout_en == !sram_we_n); // R3
    AST_OE_IN_READ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (hcount[2:0] == 3'd7 && disp_active)); // R4
    AST_READ_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |=> (pix_byte == $past(sram_din))); // R6
    AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        sram_oe_n |=> $stable(pix_byte)); // R6
    AST_ACK_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_ack || wr_hi_ack) |-> (!sram_we_n && $onehot0({wr_lo_ack, wr_hi_ack}))); // R7
    AST_NO_STROBE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_we_n && !sram_oe_n)); // R9
endmodule

bind vram_slot_arbiter vram_slot_arbiter_chk #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) i_chk (.*);

// File: tb/test_vram_slot_arbiter.sv
module test_vram_slot_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  hcount = '0;
    logic [9:0]  vcount = '0;
    logic        disp_active = 1'b0;
    logic [13:0] snoop_word_addr = '0;
    logic [7:0]  wr_lo_byte = '0;
    logic [7:0]  wr_hi_byte = '0;
    logic        wr_lo_pend = 1'b0;
    logic        wr_hi_pend = 1'b0;
    logic [14:0] sram_addr;
    logic [7:0]  sram_dout;
    logic        sram_dout_en;
    logic [7:0]  sram_din;
    logic        sram_oe_n;
    logic        sram_we_n;
    logic        wr_lo_ack;
    logic        wr_hi_ack;
    logic [7:0]  pix_byte;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [7:0] exp_pix;

    always #4 clk = ~clk;

    // SRAM model: read data is a fixed function of the address.
    function automatic logic [7:0] mem_of(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'hA5;
    endfunction
    assign sram_din = !sram_oe_n ? mem_of(sram_addr) : 8'h5A;

    vram_slot_arbiter i_vram_slot_arbiter (.*);

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check the decoded pins, model the latch.
    task automatic step(input int h, input int v, input bit dact, input bit plo, input bit phi,
                        input int word, input int lo, input int hi);
        int slot;
        int exp_addr;
        bit we_exp;
        bit oe_exp;
        bit lo_w;
        bit hi_w;
        @(negedge clk);
        check("R6", "pix_byte held/captured", pix_byte, exp_pix);
        hcount = 10'(h); vcount = 10'(v); disp_active = dact;
        wr_lo_pend = plo; wr_hi_pend = phi;
        snoop_word_addr = 14'(word); wr_lo_byte = 8'(lo); wr_hi_byte = 8'(hi);
        #1;
        slot = h % 8;
        lo_w = (slot == 1) && plo;
        hi_w = (slot == 2) && phi;
        we_exp = lo_w || hi_w;
        oe_exp = (slot == 7) && dact;
        if (lo_w)      exp_addr = (word * 2) % 32768;
        else if (hi_w) exp_addr = (word * 2 + 1) % 32768;
        else           exp_addr = (v * 64 + ((h / 8 + 1) % 64)) % 32768;
        if (lo_w) begin
            check("R1", "we_n", sram_we_n, 0);
            check("R1", "addr", sram_addr, exp_addr);
            check("R1", "dout", sram_dout, lo & 255);
        end else if (hi_w) begin
            check("R2", "we_n", sram_we_n, 0);
            check("R2", "addr", sram_addr, exp_addr);
            check("R2", "dout", sram_dout, hi & 255);
        end else begin
            check("R3", "we_n", sram_we_n, 1);
            check("R5", "fetch addr", sram_addr, exp_addr);
        end
        check("R3", "dout_en", sram_dout_en, we_exp);
        check("R4", "oe_n", sram_oe_n, !oe_exp);
        check("R7", "lo ack", wr_lo_ack, lo_w);
        check("R7", "hi ack", wr_hi_ack, hi_w);
        check("R9", "strobe clash", (!sram_we_n && !sram_oe_n), 0);
        if (oe_exp) exp_pix = mem_of(15'(exp_addr));
    endtask

    initial begin
        int n;
        int lines [6] = '{0, 1, 170, 341, 342, 511};
        exp_pix = 8'h00;
        // Reset while a low-byte write slot and the read slot are requested.
        hcount = 10'd1; wr_lo_pend = 1'b1; wr_hi_pend = 1'b1; disp_active = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", "we_n in reset", sram_we_n, 1);
        check("R8", "dout_en in reset", sram_dout_en, 0);
        check("R8", "lo ack in reset", wr_lo_ack, 0);
        hcount = 10'd7;
        #1;
        check("R8", "oe_n in reset", sram_oe_n, 1);
        check("R8", "pix_byte after reset", pix_byte, 0);
        hcount = 10'd2;
        #1;
        check("R8", "hi ack in reset", wr_hi_ack, 0);
        rst_n = 1'b1;
        // Full lines, all slots, with the requests varied per cycle.
        n = 0;
        foreach (lines[li]) begin
            for (int h = 0; h < 800; h++) begin
                step(h, lines[li], ((n / 13) % 4) != 0, ((n * 7) % 5) < 3, ((n * 11) % 7) < 4,
                     (lines[li] * 37 + h * 13) % 16384, n % 256, (n * 3 + 17) % 256);
                n++;
            end
        end
        // Pending flags low for a whole line: no write may happen.
        for (int h = 0; h < 800; h++) step(h, 20, 1'b1, 1'b0, 1'b0, 16383, 255, 255);
        step(8, 20, 1'b0, 1'b0, 1'b0, 0, 0, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule